// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block owns the floating-point status word of a processor. An external floating-point datapath reports, once per completed operation, which IEEE conditions it raised (invalid, divide-by-zero, overflow, underflow, inexact) and whether it met a denormal operand or produced a denormal result. On that strobe the unit replaces the per-operation cause field, accumulates sticky flags for conditions whose trap is not enabled, keeps a summary bit current, and asks for a floating-point exception one cycle later when an enabled cause occurred.

Software can also write the word. Only a fixed mask of bits takes the written data. The cause field keeps its previous contents and the summary bit is always recomputed from the flags. The rounding-mode field is driven straight back to the datapath. A small state machine with two states, `TRAP_IDLE` and `TRAP_RAISE`, produces the exception request. Its transitions are: `IDLE->RAISE` on an accepted operation with an enabled cause, `RAISE->RAISE` when the next accepted operation also traps, and `RAISE->IDLE` otherwise.

Bit layout of the status word: rounding mode [1:0]. Causes [7:2], in the order invalid, overflow, divide-by-zero, underflow, inexact, unimplemented (bit 7). Denormal-flush control at bit 8. Trap enables [14:10] and sticky flags [30:26], each in the same five-condition order. Summary at bit 31.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset the status word is 0, the rounding mode is 0 and the exception request is low.
- R2: An accepted operation strobe (op_valid high, sw_we low) replaces all six cause bits [7:2] with the causes of that operation, so causes from earlier operations are cleared. Without a strobe or write the word holds.
- R3: Each IEEE condition sets its cause bit (invalid bit 2, overflow 3, divide-by-zero 4, underflow 5, inexact 6). It sets its sticky flag (bits 26..30 in the same order) only when its enable (bits 10..14) is 0. Flags are never cleared by an operation.
- R4: A denormal input or output indication sets cause bit 7, unless the flush control bit 8 is 1.
- R5: Bit 31 equals the OR of flag bits [30:26] after every update.
- R6: trap_req is high in the cycle after an accepted strobe exactly when (causes AND {1, enables}) is nonzero, so cause bit 7 always traps. Otherwise it is low.
- R7: A software write loads the bits of mask 0x7FFFFF03 from sw_wdata. Bits [7:2] keep their old value and bit 31 is recomputed from the new flags.
- R8: round_mode always shows bits [1:0]: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R9: When sw_we and op_valid are high in the same cycle, the write is applied and the operation is dropped: the causes are unchanged and no request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | One-cycle strobe: an FP operation completed |
| ev_invalid | input | 1 | Invalid-operation condition of that operation |
| ev_divzero | input | 1 | Divide-by-zero condition |
| ev_overflow | input | 1 | Overflow condition |
| ev_underflow | input | 1 | Underflow condition |
| ev_inexact | input | 1 | Inexact condition |
| ev_denorm_in | input | 1 | Denormal operand seen |
| ev_denorm_out | input | 1 | Denormal result produced |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| status_word | output | 32 | Current status word |
| round_mode | output | 2 | Rounding mode to the datapath |
| trap_req | output | 1 | One-cycle floating-point exception request |

## Verification
Every result of this block falls due exactly one clock edge after its stimulus. The status word, the rounding mode and the exception request all change on the edge that samples the strobe or write, and the bench samples them shortly after that edge. The driver drives inputs on the falling edge and pushes one expected item per cycle, computed from the requirements. The monitor pops that item two nanoseconds after the following rising edge. An idle cycle after each trapping operation confirms that the request falls again.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    // Number of IEEE conditions and cause width (IEEE conditions + unimplemented)
    localparam int unsigned FPX_NCOND   = 5;
    localparam int unsigned FPX_CAUSE_W = FPX_NCOND + 1;

    // Default layout of the status word
    localparam int unsigned FPX_W         = 32;
    localparam int unsigned FPX_RM_LSB    = 0;
    localparam int unsigned FPX_CAUSE_LSB = 2;
    localparam int unsigned FPX_DN_BIT    = 8;
    localparam int unsigned FPX_EN_LSB    = 10;
    localparam int unsigned FPX_FLAG_LSB  = 26;
    localparam int unsigned FPX_SUM_BIT   = 31;
    localparam logic [31:0] FPX_WR_MASK   = 32'h7FFF_FF03;

    // Index of each condition inside cause/enable/flag fields
    localparam int unsigned IDX_INVALID  = 0;
    localparam int unsigned IDX_OVERFLOW = 1;
    localparam int unsigned IDX_DIVZERO  = 2;
    localparam int unsigned IDX_UNDERFL  = 3;
    localparam int unsigned IDX_INEXACT  = 4;
    localparam int unsigned IDX_UNIMPL   = 5;

    typedef enum logic [0:0] {
        TRAP_IDLE  = 1'b0,
        TRAP_RAISE = 1'b1
    } trap_state_e;

    typedef struct packed {
        logic denorm_out;
        logic denorm_in;
        logic inexact;
        logic underflow;
        logic divzero;
        logic overflow;
        logic invalid;
    } fpx_events_t;

endpackage

// File: rtl/fpx_cause_gen.sv
module fpx_cause_gen
    import fpx_pkg::*;
#(
    parameter int unsigned CAUSE_W = FPX_CAUSE_W
) (
    input  fpx_events_t        events,
    input  logic               flush_denorm,
    output logic [CAUSE_W-1:0] cause
);

    logic denorm_seen;

    assign denorm_seen = events.denorm_in | events.denorm_out;

    always_comb begin
        cause               = '0;
        cause[IDX_INVALID]  = events.invalid;
        cause[IDX_OVERFLOW] = events.overflow;
        cause[IDX_DIVZERO]  = events.divzero;
        cause[IDX_UNDERFL]  = events.underflow;
        cause[IDX_INEXACT]  = events.inexact;
        cause[IDX_UNIMPL]   = denorm_seen & ~flush_denorm;
    end

endmodule

// File: rtl/fpx_status_merge.sv
module fpx_status_merge
    import fpx_pkg::*;
#(
    parameter int unsigned W         = FPX_W,
    parameter int unsigned NCOND     = FPX_NCOND,
    parameter int unsigned CAUSE_LSB = FPX_CAUSE_LSB,
    parameter int unsigned EN_LSB    = FPX_EN_LSB,
    parameter int unsigned FLAG_LSB  = FPX_FLAG_LSB,
    parameter int unsigned SUM_BIT   = FPX_SUM_BIT,
    parameter logic [W-1:0] WR_MASK  = W'(FPX_WR_MASK)
) (
    input  logic [W-1:0]     cur_word,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             op_fire,
    input  logic [NCOND:0]   cause,
    output logic [W-1:0]     nxt_word
);

    localparam int unsigned CW = NCOND + 1;

    logic [NCOND-1:0] sticky_set;

    for (genvar i = 0; i < NCOND; i++) begin : g_sticky
        assign sticky_set[i] = cause[i] & ~cur_word[EN_LSB + i];
    end

    always_comb begin
        nxt_word = cur_word;
        if (wr_en) begin
            nxt_word = (wr_data & WR_MASK) | (cur_word & ~WR_MASK);
        end else if (op_fire) begin
            nxt_word[CAUSE_LSB +: CW]   = cause;
            nxt_word[FLAG_LSB +: NCOND] = cur_word[FLAG_LSB +: NCOND] | sticky_set;
        end
        nxt_word[SUM_BIT] = |nxt_word[FLAG_LSB +: NCOND];
    end

endmodule

// File: rtl/fpx_trap_fsm.sv
module fpx_trap_fsm
    import fpx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_fire,
    input  logic trap_hit,
    output logic trap_req
);

    trap_state_e state_q;
    trap_state_e state_d;
    logic        raise;

    assign raise = op_fire & trap_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRAP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRAP_IDLE:  state_d = raise ? TRAP_RAISE : TRAP_IDLE;
            TRAP_RAISE: state_d = raise ? TRAP_RAISE : TRAP_IDLE;
            default:    state_d = TRAP_IDLE;
        endcase
    end

    always_comb begin
        trap_req = 1'b0;
        unique case (state_q)
            TRAP_IDLE:  trap_req = 1'b0;
            TRAP_RAISE: trap_req = 1'b1;
            default:    trap_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
    import fpx_pkg::*;
#(
    parameter int unsigned W         = FPX_W,
    parameter int unsigned NCOND     = FPX_NCOND,
    parameter int unsigned RM_LSB    = FPX_RM_LSB,
    parameter int unsigned CAUSE_LSB = FPX_CAUSE_LSB,
    parameter int unsigned DN_BIT    = FPX_DN_BIT,
    parameter int unsigned EN_LSB    = FPX_EN_LSB,
    parameter int unsigned FLAG_LSB  = FPX_FLAG_LSB,
    parameter int unsigned SUM_BIT   = FPX_SUM_BIT,
    parameter logic [W-1:0] WR_MASK  = W'(FPX_WR_MASK)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic         ev_invalid,
    input  logic         ev_divzero,
    input  logic         ev_overflow,
    input  logic         ev_underflow,
    input  logic         ev_inexact,
    input  logic         ev_denorm_in,
    input  logic         ev_denorm_out,
    input  logic         sw_we,
    input  logic [W-1:0] sw_wdata,
    output logic [W-1:0] status_word,
    output logic [1:0]   round_mode,
    output logic         trap_req
);

    localparam int unsigned CW = NCOND + 1;

    fpx_events_t   events;
    logic [CW-1:0] cause;
    logic [CW-1:0] trap_enable;
    logic [W-1:0]  word_q;
    logic [W-1:0]  word_d;
    logic          op_fire;
    logic          trap_hit;

    assign events = '{denorm_out: ev_denorm_out, denorm_in: ev_denorm_in,
                      inexact: ev_inexact, underflow: ev_underflow,
                      divzero: ev_divzero, overflow: ev_overflow,
                      invalid: ev_invalid};

    // a software write in the same cycle takes priority over the operation
    assign op_fire = op_valid & ~sw_we;

    fpx_cause_gen #(.CAUSE_W(CW)) u_cause (
        .events       (events),
        .flush_denorm (word_q[DN_BIT]),
        .cause        (cause)
    );

    fpx_status_merge #(
        .W(W), .NCOND(NCOND), .CAUSE_LSB(CAUSE_LSB), .EN_LSB(EN_LSB),
        .FLAG_LSB(FLAG_LSB), .SUM_BIT(SUM_BIT), .WR_MASK(WR_MASK)
    ) u_merge (
        .cur_word (word_q),
        .wr_en    (sw_we),
        .wr_data  (sw_wdata),
        .op_fire  (op_fire),
        .cause    (cause),
        .nxt_word (word_d)
    );

    // unimplemented-processing cause has no enable bit: always armed
    assign trap_enable = {1'b1, word_q[EN_LSB +: NCOND]};
    assign trap_hit    = |(cause & trap_enable);

    fpx_trap_fsm u_trap (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_fire  (op_fire),
        .trap_hit (trap_hit),
        .trap_req (trap_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign status_word = word_q;
    assign round_mode  = word_q[RM_LSB +: 2];

endmodule

// File: rtl/fpx_status_checker.sv
module fpx_status_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic        sw_we,
    input logic [31:0] sw_wdata,
    input logic [31:0] status_word,
    input logic [1:0]  round_mode,
    input logic        trap_req
);

    AST_TRAP_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_valid && !sw_we)); // R6

    AST_SUMMARY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid || sw_we) |=> (status_word[31] == (|status_word[30:26]))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !sw_we) |=> $stable(status_word)); // R2

    AST_WRITE_KEEPS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (status_word[7:2] == $past(status_word[7:2]))); // R7

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && op_valid) |=> !trap_req); // R9

    AST_RM_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (round_mode == $past(sw_wdata[1:0]))); // R8

    AST_FLUSH_NO_UNIMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_we && status_word[8]) |=> !status_word[7]); // R4

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_we) |=> (($past(status_word[30:26]) & ~status_word[30:26]) == 5'b0)); // R3

endmodule

bind fpx_status_unit fpx_status_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .sw_we       (sw_we),
    .sw_wdata    (sw_wdata),
    .status_word (status_word),
    .round_mode  (round_mode),
    .trap_req    (trap_req)
);

// File: tb/sim_fpx_status_unit.sv
`timescale 1ns/1ps
module sim_fpx_status_unit;

    typedef struct {
        logic [31:0] st;
        logic        trap;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        ev_invalid = 1'b0, ev_divzero = 1'b0, ev_overflow = 1'b0;
    logic        ev_underflow = 1'b0, ev_inexact = 1'b0;
    logic        ev_denorm_in = 1'b0, ev_denorm_out = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = 32'h0;
    logic [31:0] status_word;
    logic [1:0]  round_mode;
    logic        trap_req;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t sb[$];
    logic [31:0] model = 32'h0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    fpx_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .ev_invalid(ev_invalid), .ev_divzero(ev_divzero), .ev_overflow(ev_overflow),
        .ev_underflow(ev_underflow), .ev_inexact(ev_inexact),
        .ev_denorm_in(ev_denorm_in), .ev_denorm_out(ev_denorm_out),
        .sw_we(sw_we), .sw_wdata(sw_wdata),
        .status_word(status_word), .round_mode(round_mode), .trap_req(trap_req)
    );

    // driver: one call per cycle; ev = {dout,din,x,u,z,o,v}
    task automatic step(input logic we, input logic [31:0] wd, input logic op,
                        input logic [6:0] ev, input string tag);
        exp_t       e;
        logic [5:0] c;
        logic       t;
        @(negedge clk);
        sw_we = we; sw_wdata = wd; op_valid = op;
        ev_invalid = ev[0]; ev_overflow = ev[1]; ev_divzero = ev[2];
        ev_underflow = ev[3]; ev_inexact = ev[4];
        ev_denorm_in = ev[5]; ev_denorm_out = ev[6];
        t = 1'b0;
        if (we) begin
            model = (wd & 32'h7FFF_FF03) | (model & ~32'h7FFF_FF03);
        end else if (op) begin
            c = {(ev[5] | ev[6]) & ~model[8], ev[4:0]};
            t = |(c & {1'b1, model[14:10]});
            model[30:26] = model[30:26] | (c[4:0] & ~model[14:10]);
            model[7:2] = c;
        end
        model[31] = |model[30:26];
        e.st = model; e.trap = t; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 32'h0, 1'b0, 7'h00, tag);
    endtask

    // monitor: compares after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_tests++;
                if (status_word !== e.st || round_mode !== e.st[1:0] || trap_req !== e.trap) begin
                    n_fail++;
                    $display("FAIL %s: word=%h rm=%0d trap=%b expected word=%h rm=%0d trap=%b",
                             e.tag, status_word, round_mode, trap_req, e.st, e.st[1:0], e.trap);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_tests++;
        if (status_word !== 32'h0 || round_mode !== 2'd0 || trap_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: word=%h rm=%0d trap=%b expected 0/0/0", status_word, round_mode, trap_req);
        end
        @(negedge clk); rst_n = 1'b1;
        idle("R1 idle after reset");
        step(0, 0, 1, 7'b0000001, "R3 invalid sets cause and flag, R5 summary");
        step(0, 0, 1, 7'b0010000, "R2 inexact replaces old cause");
        idle("R2 hold without strobe");
        step(0, 0, 1, 7'b0001110, "R3 three conditions together");
        step(1, 32'h0000_1000, 0, 7'h00, "R7 write enables divzero, clears flags, R5");
        step(1, 32'hFFFF_FFFF, 0, 7'h00, "R7 all-ones write keeps cause, summary recomputed");
        step(1, 32'h0000_1000, 0, 7'h00, "R7 restore enable");
        step(0, 0, 1, 7'b0000100, "R6 enabled divzero traps, R3 no flag");
        idle("R6 request lasts one cycle");
        step(0, 0, 1, 7'b0000010, "R6 disabled overflow no trap");
        step(0, 0, 1, 7'b0100000, "R4 denormal input sets unimplemented cause, R6 traps");
        step(0, 0, 1, 7'b1000000, "R4 denormal output, R6 back-to-back trap");
        idle("R6 falls after burst");
        step(1, 32'h0000_0100, 0, 7'h00, "R7 set flush control");
        step(0, 0, 1, 7'b1100000, "R4 flush suppresses unimplemented cause");
        step(1, 32'h0000_0001, 0, 7'h00, "R8 mode toward zero");
        step(1, 32'h0000_0002, 0, 7'h00, "R8 mode toward +inf");
        step(1, 32'h0000_0003, 0, 7'h00, "R8 mode toward -inf");
        step(1, 32'h0000_4000, 0, 7'h00, "R8 mode nearest-even, enable inexact");
        step(1, 32'h0000_4000, 1, 7'b0010001, "R9 write wins over strobe");
        idle("R9 no request after dropped op");
        step(0, 0, 1, 7'b0010001, "R6 inexact enabled traps, R3 invalid flag only");
        idle("R2 final hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule